// File: doc/BRIEF.md
# Host Memory Window Decoder

This block lets a host reach a 4 KB page of internal registers and buffers through ordinary memory cycles, at an address the host chooses. Software loads a base address and a control word through a small configuration port. Each host bus cycle is then compared against that base. A match raises a hit flag and presents the 12-bit offset inside the page. The matching read or write strobe is forwarded to the internal page one clock later.

Two decode modes are available. In the wide mode the window may sit anywhere in a 16 MB space. The upper four address lines are sampled while the address-latch strobe is high and held after it falls, and only the full-range memory strobes are used. In the low mode the window is confined to the first 1 MB. A cycle matches only while the chip-select input is low, and only the below-1MB memory strobes count. A status word reports whether initialization has finished and whether the upper-address decode circuit is fitted. A pass-through selects the chip-select line that serves that decode circuit.

Top module: `host_mem_window`

## Requirements
- R1: After reset the base register, the enable and mode bits and the latched upper address are all zero, and hit_o, rd_o, wr_o, ext_cs_o and off_o are 0.
- R2: When control bit 10 (window enable) is 0, hit_o, rd_o and wr_o stay 0 for every bus cycle.
- R3: Wide mode is selected when control bit 9 is 1. In this mode hit_o rises one clock after a cycle in which the latched upper lines equal base bits 23:20 and sa[19:12] equals base bits 19:12. off_o then carries sa[11:0] from that cycle, and off_o is 0 whenever hit_o is 0.
- R4: The latched upper address follows la_hi while ale is 1. It holds its value while ale is 0, so a change on la_hi with ale low has no effect on decoding.
- R5: Low mode is selected when control bit 9 is 0. In this mode a hit needs chip_sel_n low and sa[19:12] equal to base bits 19:12. Base bits 23:20 and the latched upper lines are ignored.
- R6: rd_o (wr_o) is 1 one clock after a hit cycle in which the active read (write) strobe was low. The active strobes are mem_rd_n/mem_wr_n in wide mode and low_rd_n/low_wr_n in low mode. The inactive pair has no effect.
- R7: While init_done is 0, rd_o and wr_o are held at 0, and hit_o and off_o still follow R3 and R5.
- R8: stat_o is combinational: bit 7 equals init_done, bit 11 equals ext_present, and all other bits are 0.
- R9: A configuration write (cfg_wr high) updates state as follows. At offset 0x02C it loads the base from cfg_wdata[23:12]. At offset 0x116 it loads the enable bit from cfg_wdata[10] and the mode bit from cfg_wdata[9]. Writes to other offsets change nothing. A bus cycle in the same clock as a write is decoded against the old values.
- R10: ext_cs_o is 1 one clock after a cycle in which ext_sel and ext_present are both 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration offset in the page |
| cfg_wdata | input | 32 | Configuration write data |
| init_done | input | 1 | Initialization finished |
| ext_present | input | 1 | Upper-address decode circuit fitted |
| ext_sel | input | 1 | Request to drive the decode-circuit select |
| ale | input | 1 | Address-latch strobe |
| la_hi | input | 4 | Upper host address lines 23:20 |
| sa | input | 20 | Host address lines 19:0 |
| chip_sel_n | input | 1 | Low-mode chip select, active low |
| mem_rd_n | input | 1 | Full-range memory read, active low |
| mem_wr_n | input | 1 | Full-range memory write, active low |
| low_rd_n | input | 1 | Below-1MB memory read, active low |
| low_wr_n | input | 1 | Below-1MB memory write, active low |
| hit_o | output | 1 | Window hit, registered |
| off_o | output | 12 | Offset inside the page |
| rd_o | output | 1 | Internal read strobe |
| wr_o | output | 1 | Internal write strobe |
| ext_cs_o | output | 1 | Select for the upper-address decode circuit |
| stat_o | output | 16 | Status word |

## Verification
A configuration write can land in the same clock as a bus cycle aimed at the window. The bench drives a base rewrite together with a read of the old page. It expects that cycle to hit against the old base, and the identical read on the next clock to miss. A second overlap pairs a hold of the upper-address latch with a change of la_hi. The bench expects the decode to use the held value until ale is raised again.

// File: rtl/host_mem_window.sv
module host_mem_window #(
  parameter int ADDR_W = 24,
  parameter int LOW_W  = 20,
  parameter int PAGE_W = 12,
  parameter logic [11:0] BASE_OFS = 12'h02C,
  parameter logic [11:0] CTL_OFS  = 12'h116
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic [11:0]              cfg_addr,
  input  logic [31:0]              cfg_wdata,
  input  logic                     init_done,
  input  logic                     ext_present,
  input  logic                     ext_sel,
  input  logic                     ale,
  input  logic [ADDR_W-LOW_W-1:0]  la_hi,
  input  logic [LOW_W-1:0]         sa,
  input  logic                     chip_sel_n,
  input  logic                     mem_rd_n,
  input  logic                     mem_wr_n,
  input  logic                     low_rd_n,
  input  logic                     low_wr_n,
  output logic                     hit_o,
  output logic [PAGE_W-1:0]        off_o,
  output logic                     rd_o,
  output logic                     wr_o,
  output logic                     ext_cs_o,
  output logic [15:0]              stat_o
);
  localparam int LA_W   = ADDR_W - LOW_W;
  localparam int BASE_W = ADDR_W - PAGE_W;
  localparam int PG_W   = LOW_W - PAGE_W;
  localparam int EN_BIT   = 10;
  localparam int MODE_BIT = 9;
  localparam int ST_INIT  = 7;
  localparam int ST_EXT   = 11;

  logic [BASE_W-1:0] base_q;
  logic              en_q, wide_q;
  logic [LA_W-1:0]   la_q;
  logic              unused_bits;

  assign unused_bits = ^cfg_wdata;

  wire cfg_base = cfg_wr && (cfg_addr == BASE_OFS);
  wire cfg_ctl  = cfg_wr && (cfg_addr == CTL_OFS);

  wire page_match  = sa[LOW_W-1:PAGE_W] == base_q[PG_W-1:0];
  wire upper_match = la_q == base_q[BASE_W-1 -: LA_W];
  wire win_hit     = en_q && page_match && (wide_q ? upper_match : !chip_sel_n);
  wire rd_req      = wide_q ? !mem_rd_n : !low_rd_n;
  wire wr_req      = wide_q ? !mem_wr_n : !low_wr_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      en_q     <= 1'b0;
      wide_q   <= 1'b0;
      la_q     <= '0;
      hit_o    <= 1'b0;
      off_o    <= '0;
      rd_o     <= 1'b0;
      wr_o     <= 1'b0;
      ext_cs_o <= 1'b0;
    end else begin
      if (cfg_base) base_q <= cfg_wdata[ADDR_W-1:PAGE_W];
      if (cfg_ctl) begin
        en_q   <= cfg_wdata[EN_BIT];
        wide_q <= cfg_wdata[MODE_BIT];
      end
      if (ale) la_q <= la_hi;
      hit_o    <= win_hit;
      off_o    <= win_hit ? sa[PAGE_W-1:0] : '0;
      rd_o     <= win_hit && init_done && rd_req;
      wr_o     <= win_hit && init_done && wr_req;
      ext_cs_o <= ext_sel && ext_present;
    end
  end

  always_comb begin
    stat_o          = '0;
    stat_o[ST_INIT] = init_done;
    stat_o[ST_EXT]  = ext_present;
  end
endmodule

// File: rtl/host_mem_window_chk.sv
module host_mem_window_chk #(
  parameter int LA_W   = 4,
  parameter int PAGE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_done,
  input logic              ale,
  input logic              ext_sel,
  input logic              ext_present,
  input logic [PAGE_W-1:0] sa_lo,
  input logic              en_q,
  input logic [LA_W-1:0]   la_q,
  input logic              hit_o,
  input logic [PAGE_W-1:0] off_o,
  input logic              rd_o,
  input logic              wr_o,
  input logic              ext_cs_o
);
  p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !hit_o);
  p_off_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> off_o == $past(sa_lo));
  p_off_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> off_o == '0);
  p_la_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(la_q));
  p_strobe_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_o || wr_o) |-> hit_o);
  p_init_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |=> (!rd_o && !wr_o));
  p_ext_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && ext_present) |=> ext_cs_o);
endmodule

bind host_mem_window host_mem_window_chk #(.LA_W(LA_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_done(init_done), .ale(ale),
  .ext_sel(ext_sel), .ext_present(ext_present), .sa_lo(sa[PAGE_W-1:0]),
  .en_q(en_q), .la_q(la_q), .hit_o(hit_o), .off_o(off_o),
  .rd_o(rd_o), .wr_o(wr_o), .ext_cs_o(ext_cs_o)
);

// File: tb/host_mem_window_bench.sv
module host_mem_window_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        init_done = 1'b1, ext_present = 1'b0, ext_sel = 1'b0;
  logic        ale = 1'b0;
  logic [3:0]  la_hi = '0;
  logic [19:0] sa = '0;
  logic        chip_sel_n = 1'b1, mem_rd_n = 1'b1, mem_wr_n = 1'b1;
  logic        low_rd_n = 1'b1, low_wr_n = 1'b1;
  logic        hit_o, rd_o, wr_o, ext_cs_o;
  logic [11:0] off_o;
  logic [15:0] stat_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_mem_window u_host_mem_window (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .init_done(init_done), .ext_present(ext_present),
    .ext_sel(ext_sel), .ale(ale), .la_hi(la_hi), .sa(sa),
    .chip_sel_n(chip_sel_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .low_rd_n(low_rd_n), .low_wr_n(low_wr_n), .hit_o(hit_o), .off_o(off_o),
    .rd_o(rd_o), .wr_o(wr_o), .ext_cs_o(ext_cs_o), .stat_o(stat_o)
  );

  typedef struct packed {
    logic        hit;
    logic        rd;
    logic        wr;
    logic [11:0] off;
    logic        cs;
  } exp_t;

  exp_t  eq[$];
  string tq[$];
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;

  logic [11:0] m_base = '0;
  logic        m_en = 1'b0, m_wide = 1'b0;
  logic [3:0]  m_la = '0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic quiet();
    cfg_wr = 1'b0; ale = 1'b0; chip_sel_n = 1'b1;
    mem_rd_n = 1'b1; mem_wr_n = 1'b1; low_rd_n = 1'b1; low_wr_n = 1'b1;
  endtask

  task automatic cyc(input string tag);
    exp_t e;
    logic h, rq, wq;
    h  = m_en && (sa[19:12] == m_base[7:0]) &&
         (m_wide ? (m_la == m_base[11:8]) : !chip_sel_n);
    rq = m_wide ? !mem_rd_n : !low_rd_n;
    wq = m_wide ? !mem_wr_n : !low_wr_n;
    e.hit = h;
    e.rd  = h && init_done && rq;
    e.wr  = h && init_done && wq;
    e.off = h ? sa[11:0] : 12'h000;
    e.cs  = ext_sel && ext_present;
    @(posedge clk);
    eq.push_back(e);
    tq.push_back(tag);
    if (cfg_wr && cfg_addr == 12'h02C) m_base = cfg_wdata[23:12];
    if (cfg_wr && cfg_addr == 12'h116) begin
      m_en = cfg_wdata[10]; m_wide = cfg_wdata[9];
    end
    if (ale) m_la = la_hi;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (eq.size() > 0) begin
      exp_t  e;
      string t;
      e = eq.pop_front();
      t = tq.pop_front();
      chk(t, {15'd0, hit_o, rd_o, wr_o, off_o, ext_cs_o}, {15'd0, e});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {hit_o, rd_o, wr_o, ext_cs_o, off_o}, 16'h0000);
    // R8 status word
    init_done = 1'b0; ext_present = 1'b0; #1;
    chk("R8", {16'd0, stat_o}, 32'h0000);
    init_done = 1'b1; ext_present = 1'b1; #1;
    chk("R8", {16'd0, stat_o}, 32'h0880);
    ext_present = 1'b0; #1;
    chk("R8", {16'd0, stat_o}, 32'h0080);

    // R9 base load, window still disabled
    quiet(); cfg_wr = 1'b1; cfg_addr = 12'h02C; cfg_wdata = 32'h0034_5000; cyc("R9");
    // R2 disabled: matching access produces nothing
    quiet(); chip_sel_n = 1'b0; sa = 20'h45123; low_rd_n = 1'b0; cyc("R2");
    // enable, low mode
    quiet(); cfg_wr = 1'b1; cfg_addr = 12'h116; cfg_wdata = 32'h0000_0400; cyc("R9");
    // R5 low mode hit with read
    quiet(); chip_sel_n = 1'b0; sa = 20'h45123; low_rd_n = 1'b0; cyc("R5");
    quiet(); chip_sel_n = 1'b1; sa = 20'h45123; low_rd_n = 1'b0; cyc("R5");
    quiet(); chip_sel_n = 1'b0; sa = 20'h46123; low_rd_n = 1'b0; cyc("R5");
    // R6 full-range read strobe ignored in low mode, top offset
    quiet(); chip_sel_n = 1'b0; sa = 20'h45FFF; low_wr_n = 1'b0; mem_rd_n = 1'b0; cyc("R6");
    // R7 strobes suppressed before init
    quiet(); init_done = 1'b0; chip_sel_n = 1'b0; sa = 20'h45008; low_rd_n = 1'b0; cyc("R7");
    init_done = 1'b1;

    // wide mode
    quiet(); cfg_wr = 1'b1; cfg_addr = 12'h116; cfg_wdata = 32'h0000_0600; cyc("R9");
    // R4 latch upper lines under ale
    quiet(); ale = 1'b1; la_hi = 4'h3; sa = 20'h45000; mem_wr_n = 1'b0; cyc("R4");
    quiet(); la_hi = 4'h7; sa = 20'h45000; mem_wr_n = 1'b0; cyc("R3");
    quiet(); la_hi = 4'h3; ale = 1'b1; la_hi = 4'h2; sa = 20'h45ABC; mem_rd_n = 1'b0; cyc("R4");
    quiet(); la_hi = 4'h3; sa = 20'h45ABC; mem_rd_n = 1'b0; cyc("R4");
    quiet(); ale = 1'b1; la_hi = 4'h3; cyc("R4");
    // R6 low strobes ignored in wide mode; chip select irrelevant
    quiet(); la_hi = 4'h0; sa = 20'h45100; low_rd_n = 1'b0; low_wr_n = 1'b0; cyc("R6");
    quiet(); chip_sel_n = 1'b0; sa = 20'h45200; mem_rd_n = 1'b0; mem_wr_n = 1'b0; cyc("R3");

    // R9 same-cycle base rewrite uses the old base
    quiet(); cfg_wr = 1'b1; cfg_addr = 12'h02C; cfg_wdata = 32'h0099_9000;
    sa = 20'h45010; mem_rd_n = 1'b0; cyc("R9");
    quiet(); sa = 20'h45010; mem_rd_n = 1'b0; cyc("R9");
    // R9 write to an unrelated offset is ignored
    quiet(); cfg_wr = 1'b1; cfg_addr = 12'h030; cfg_wdata = 32'h0034_5000; cyc("R9");
    quiet(); sa = 20'h45010; mem_rd_n = 1'b0; cyc("R9");
    // new base reached with matching upper lines
    quiet(); ale = 1'b1; la_hi = 4'h9; cyc("R4");
    quiet(); sa = 20'h99444; mem_wr_n = 1'b0; cyc("R3");

    // R10 decode-circuit select
    quiet(); ext_sel = 1'b1; ext_present = 1'b1; cyc("R10");
    quiet(); ext_sel = 1'b1; ext_present = 1'b0; cyc("R10");
    ext_sel = 1'b0;

    // R2 disable again
    quiet(); cfg_wr = 1'b1; cfg_addr = 12'h116; cfg_wdata = 32'h0000_0200; cyc("R9");
    quiet(); sa = 20'h99444; mem_wr_n = 1'b0; cyc("R2");

    quiet();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule